// File: doc/BRIEF.md
# Carrier Offset Tracking Loop

This block removes the carrier frequency offset between a remote transmitter and the local receiver. It consumes a stream of signed instantaneous-frequency samples from a demodulator, each marked by a valid strobe. Two registers follow the upper and lower extremes of that stream, and their midpoint serves as the estimate of the carrier. The block subtracts a programmable target from this midpoint to form an error. A proportional-integral controller filters the error and drives a signed correction word that a frequency synthesizer can apply.

Both the attack rate and the decay rate of the extreme trackers are programmable, as are the integral and proportional gains. Each gain is given as a right-shift amount. The integral gain dominates the response. Small shift values give a fast rise but leave more ripple and can overshoot. A lock request freezes the controller, for example after a sync word has been detected, so that long runs of equal bits in the payload do not drag the correction. Clearing the enable empties the whole loop.

Top module: `freq_track_loop`

## Requirements
- R1: While `rst_n` is low, at the following clock edge the correction and both extreme trackers are cleared to zero, so `err_o` shows `0 - target_i`.
- R2: On an update, a sample above the tracked maximum raises the maximum by (sample - maximum) >>> `peak_i`. A sample below the tracked minimum lowers the minimum by (minimum - sample) >>> `peak_i`.
- R3: On an update, an extreme that is not exceeded moves toward the current centre by its distance from the centre >>> (`leak_i` + 4).
- R4: `err_o` equals floor((maximum + minimum) / 2) - `target_i`, computed from the registered trackers without any clock delay.
- R5: On an update, the integrator adds `err_o` >>> KI, using the error value from before that update. The new correction equals the new integrator plus `err_o` >>> KP.
- R6: A `ki_i` below 8 acts as 8, and a `kp_i` below 2 acts as 2. Larger values are used unchanged.
- R7: The integrator and the correction saturate at the limits of a signed ACC_W-bit value instead of wrapping around.
- R8: While `lock_i` is high, the integrator and `corr_o` hold their values. The extreme trackers, and therefore `err_o`, keep updating.
- R9: While `enable_i` is low, the correction, the integrator and both trackers are cleared to zero at each clock edge.
- R10: An update takes place only on a clock edge where `enable_i` and `valid_i` are both high. On any other edge with `enable_i` high, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Loop enable; low clears all state |
| lock_i | input | 1 | Freezes integrator and correction |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | SAMPLE_W | Signed instantaneous frequency |
| target_i | input | SAMPLE_W | Signed target centre frequency |
| ki_i | input | 4 | Integral right-shift, clamped to at least 8 |
| kp_i | input | 3 | Proportional right-shift, clamped to at least 2 |
| peak_i | input | 3 | Attack right-shift of the extreme trackers |
| leak_i | input | 3 | Decay right-shift (plus 4) of the extreme trackers |
| corr_o | output | ACC_W | Signed frequency correction word |
| err_o | output | SAMPLE_W+1 | Signed current error |

## Verification
The bench keeps SAMPLE_W at 12 and narrows ACC_W to 14. With this width, an error near 4000 shifted by the minimum integral shift drives the integrator into both saturation limits within about a thousand samples. The correction is therefore seen pinned at +8191 and at -8192, not only in its linear range. The narrow accumulator still leaves room for several hundred cycles of alternating preamble-like input under fast and slow attack and decay settings. It also covers clamped gain codes, gaps in the strobe, a locked stretch and a disabled stretch, all compared against the model on every clock.

// File: rtl/freq_track_pkg.sv
// Shared constants and gain-clamp helpers for the carrier offset tracking loop.
package freq_track_pkg;
    localparam int KI_FLOOR = 8;
    localparam int KP_FLOOR = 2;
    localparam int LEAK_BASE = 4;

    // Raise an integral shift code below the stability floor to the floor.
    function automatic logic [3:0] clamp_ki(input logic [3:0] code);
        return (code < 4'(KI_FLOOR)) ? 4'(KI_FLOOR) : code;
    endfunction

    // Raise a proportional shift code below the stability floor to the floor.
    function automatic logic [2:0] clamp_kp(input logic [2:0] code);
        return (code < 3'(KP_FLOOR)) ? 3'(KP_FLOOR) : code;
    endfunction
endpackage

// File: rtl/ftl_envelope.sv
// Extreme tracker: follows the maximum and the minimum of the sample stream,
// attacking by diff>>>peak and decaying toward the midpoint by dist>>>(leak+4).
// Assumes the maximum never drops below the minimum (both start at zero).
module ftl_envelope
    import freq_track_pkg::*;
#(
    parameter int SW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 upd,
    input  logic signed [SW-1:0] sample,
    input  logic [2:0]           peak,
    input  logic [2:0]           leak,
    output logic signed [SW-1:0] center
);
    localparam int EW = SW + 1;

    logic signed [SW-1:0] hi_q, lo_q;
    logic signed [EW-1:0] sum, hi_x, lo_x, smp_x, ctr_x, hi_n, lo_n;
    logic [3:0]           lsh;

    // Midpoint of the two extremes (arithmetic floor).
    always_comb begin
        hi_x   = {hi_q[SW-1], hi_q};
        lo_x   = {lo_q[SW-1], lo_q};
        smp_x  = {sample[SW-1], sample};
        sum    = hi_x + lo_x;
        center = sum[EW-1:1];
        ctr_x  = {center[SW-1], center};
        lsh    = 4'(leak) + 4'(LEAK_BASE);
    end

    // Next values of the extremes: attack when exceeded, otherwise leak.
    always_comb begin
        if (smp_x > hi_x) hi_n = hi_x + ((smp_x - hi_x) >>> peak);
        else              hi_n = hi_x - ((hi_x - ctr_x) >>> lsh);
        if (smp_x < lo_x) lo_n = lo_x - ((lo_x - smp_x) >>> peak);
        else              lo_n = lo_x + ((ctr_x - lo_x) >>> lsh);
    end

    // Extreme registers with clear and update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (upd) begin
            hi_q <= hi_n[SW-1:0];
            lo_q <= lo_n[SW-1:0];
        end
    end
endmodule

// File: rtl/ftl_pi.sv
// Proportional-integral controller with shift gains and saturating integrator.
// Assumes AW exceeds EW so a shifted error always fits the integrator.
module ftl_pi #(
    parameter int EW = 13,
    parameter int AW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 upd,
    input  logic                 hold,
    input  logic signed [EW-1:0] err,
    input  logic [3:0]           ki_sh,
    input  logic [2:0]           kp_sh,
    output logic signed [AW-1:0] corr
);
    localparam int XW = AW + 2;
    localparam logic signed [XW-1:0] MAXV = XW'({1'b0, {(AW-1){1'b1}}});
    localparam logic signed [XW-1:0] MINV = -MAXV - XW'(1);

    logic signed [AW-1:0] integ_q, integ_n, corr_n;
    logic signed [XW-1:0] err_x, i_step, p_step;

    // Clip a wide value to the signed AW-bit range.
    function automatic logic signed [AW-1:0] sat(input logic signed [XW-1:0] v);
        if (v > MAXV)      return MAXV[AW-1:0];
        else if (v < MINV) return MINV[AW-1:0];
        else               return v[AW-1:0];
    endfunction

    // Gain steps and saturated next values.
    always_comb begin
        err_x   = {{(XW-EW){err[EW-1]}}, err};
        i_step  = err_x >>> ki_sh;
        p_step  = err_x >>> kp_sh;
        integ_n = sat({{2{integ_q[AW-1]}}, integ_q} + i_step);
        corr_n  = sat({{2{integ_n[AW-1]}}, integ_n} + p_step);
    end

    // Integrator and correction registers; held while locked.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            integ_q <= '0;
            corr    <= '0;
        end else if (upd && !hold) begin
            integ_q <= integ_n;
            corr    <= corr_n;
        end
    end
endmodule

// File: rtl/freq_track_loop.sv
// Top of the carrier offset tracking loop: extreme tracker, error against the
// target, and PI controller. Assumes samples and target share one signed scale.
module freq_track_loop
    import freq_track_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int ACC_W    = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable_i,
    input  logic                       lock_i,
    input  logic                       valid_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic signed [SAMPLE_W-1:0] target_i,
    input  logic [3:0]                 ki_i,
    input  logic [2:0]                 kp_i,
    input  logic [2:0]                 peak_i,
    input  logic [2:0]                 leak_i,
    output logic signed [ACC_W-1:0]    corr_o,
    output logic signed [SAMPLE_W:0]   err_o
);
    localparam int EW = SAMPLE_W + 1;

    logic signed [SAMPLE_W-1:0] center;
    logic                       upd, clr;

    // Update strobe and clear derived from enable and valid.
    always_comb begin
        upd   = enable_i && valid_i;
        clr   = !enable_i;
        err_o = {center[SAMPLE_W-1], center} - {target_i[SAMPLE_W-1], target_i};
    end

    ftl_envelope #(.SW(SAMPLE_W)) u_env (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd),
        .sample(sample_i), .peak(peak_i), .leak(leak_i), .center(center)
    );

    ftl_pi #(.EW(EW), .AW(ACC_W)) u_pi (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .hold(lock_i),
        .err(err_o), .ki_sh(clamp_ki(ki_i)), .kp_sh(clamp_kp(kp_i)),
        .corr(corr_o)
    );
endmodule

// File: rtl/ftl_checker.sv
// Temporal checks on the tracking loop ports, bound into every instance.
module ftl_checker #(
    parameter int SW = 12,
    parameter int AW = 18
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable_i,
    input logic                 lock_i,
    input logic                 valid_i,
    input logic signed [AW-1:0] corr_o,
    input logic signed [SW:0]   err_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> corr_o == '0);

    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && lock_i) |=> $stable(corr_o));

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> corr_o == '0);

    assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !valid_i) |=> ($stable(corr_o) && $stable(err_o)));
endmodule

bind freq_track_loop ftl_checker #(.SW(SAMPLE_W), .AW(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .lock_i(lock_i),
    .valid_i(valid_i), .corr_o(corr_o), .err_o(err_o)
);

// File: tb/freq_track_loop_test.sv
// Bench: behavioural model updated every clock and compared with the outputs.
module freq_track_loop_test;
    localparam int SW = 12;
    localparam int AW = 14;

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, lock = 1'b0, valid = 1'b0;
    logic signed [SW-1:0] smp = '0, tgt = '0;
    logic [3:0] ki = 4'd8;
    logic [2:0] kp = 3'd2, pk = 3'd0, lk = 3'd0;
    logic signed [AW-1:0] corr;
    logic signed [SW:0]   err;

    int checks = 0, errors = 0;
    bit done = 0;
    string req = "R1";
    longint m_hi = 0, m_lo = 0, m_int = 0, m_corr = 0;

    freq_track_loop #(.SAMPLE_W(SW), .ACC_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .enable_i(en), .lock_i(lock), .valid_i(valid),
        .sample_i(smp), .target_i(tgt), .ki_i(ki), .kp_i(kp), .peak_i(pk),
        .leak_i(lk), .corr_o(corr), .err_o(err)
    );

    always #4 clk = ~clk;

    function automatic longint sat(longint v);
        longint mx = (longint'(1) <<< (AW-1)) - 1;
        if (v > mx) return mx;
        if (v < -mx - 1) return -mx - 1;
        return v;
    endfunction

    function automatic longint m_err();
        return ((m_hi + m_lo) >>> 1) - longint'(tgt);
    endfunction

    task automatic check(string r, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", r, act, exp);
        end
    endtask

    // Reference model step at each edge, then compare before inputs change.
    always @(posedge clk) begin
        longint c, e, s;
        int kie, kpe;
        if (!rst_n || !en) begin
            m_hi = 0; m_lo = 0; m_int = 0; m_corr = 0;
        end else if (valid) begin
            c = (m_hi + m_lo) >>> 1;
            e = c - longint'(tgt);
            s = longint'(smp);
            kie = (ki < 8) ? 8 : int'(ki);
            kpe = (kp < 2) ? 2 : int'(kp);
            if (!lock) begin
                m_int = sat(m_int + (e >>> kie));
                m_corr = sat(m_int + (e >>> kpe));
            end
            if (s > m_hi) m_hi = m_hi + ((s - m_hi) >>> pk);
            else m_hi = m_hi - ((m_hi - c) >>> (int'(lk) + 4));
            if (s < m_lo) m_lo = m_lo - ((m_lo - s) >>> pk);
            else m_lo = m_lo + ((c - m_lo) >>> (int'(lk) + 4));
        end
        #3;
        if (rst_n && !done) begin
            check({req, " corr"}, longint'(corr), m_corr);
            check({req, " err"}, longint'(err), m_err());
        end
    end

    task automatic feed(int n, int base, int amp, bit gaps);
        for (int i = 0; i < n; i++) begin
            int v;
            @(negedge clk);
            valid = gaps ? (i % 3 != 0) : 1'b1;
            v = base + (((i % 2) == 1) ? amp : -amp) + ((i * 37) % 23) - 11;
            if (v > 2000) v = 2000;
            if (v < -2000) v = -2000;
            smp = SW'(v);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic signed [AW-1:0] held;
        logic signed [SW:0]   e0;
        tgt = 12'sd100;
        repeat (3) @(negedge clk);
        check("R1 reset corr", longint'(corr), 0);
        check("R1 reset err", longint'(err), -100);
        rst_n = 1'b1; tgt = '0; en = 1'b1;
        // R2/R3/R4/R5 hand-computed steps
        @(negedge clk); valid = 1'b1; smp = 12'sd600;
        @(negedge clk); smp = -12'sd400;
        check("R2 attack err", longint'(err), 300);
        check("R5 first corr", longint'(corr), 0);
        @(negedge clk); valid = 1'b0;
        check("R3 leak err", longint'(err), 91);
        check("R5 step corr", longint'(corr), 76);
        req = "R2 R4 R5 fast";
        feed(300, 300, 800, 0);
        req = "R3 slow attack";
        pk = 3'd3; lk = 3'd2; tgt = 12'sd50;
        feed(300, -200, 600, 0);
        req = "R6 clamped gains";
        ki = 4'd0; kp = 3'd0; pk = 3'd1; lk = 3'd0;
        feed(200, 400, 500, 0);
        req = "R6 large gains";
        ki = 4'd13; kp = 3'd6;
        feed(200, -300, 700, 0);
        req = "R7 saturate high";
        ki = 4'd8; kp = 3'd2; pk = 3'd0; tgt = -12'sd2000;
        feed(800, 1990, 5, 0);
        check("R7 positive limit", longint'(corr), 8191);
        req = "R7 saturate low";
        tgt = 12'sd2000;
        feed(1400, -1990, 5, 0);
        check("R7 negative limit", longint'(corr), -8192);
        req = "R10 strobe gaps";
        tgt = '0;
        feed(300, 200, 400, 1);
        req = "R8 locked";
        @(negedge clk); valid = 1'b0; lock = 1'b1;
        held = corr; e0 = err;
        feed(40, -1500, 300, 0);
        @(negedge clk); valid = 1'b0;
        check("R8 corr held", longint'(corr), longint'(held));
        check("R8 err moved", longint'(err != e0), 1);
        lock = 1'b0;
        req = "R9 disabled";
        feed(50, 500, 300, 0);
        @(negedge clk); en = 1'b0;
        feed(10, 900, 300, 0);
        check("R9 corr cleared", longint'(corr), 0);
        check("R9 err cleared", longint'(err), 0);
        req = "R9 restart";
        en = 1'b1;
        feed(100, -100, 500, 0);
        @(negedge clk); valid = 1'b0;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule